// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Pipeline

This block decides, for the instruction that is reading its operands in the third stage of a five-stage in-order pipeline, where each of its two ALU operands should come from. The first operand (latch X) normally takes the register-file value addressed by the instruction's `rb` field. The second operand (latch Y) normally takes the value addressed by `rc`, or an immediate that was merged in upstream. When an older ALU instruction, still in stage 4 or stage 5, is about to write the register being read, the block redirects the operand to that instruction's result bus. It does this before the result reaches the register file.

The unit is purely combinational. For each operand it produces a 2-bit select code and the selected data word, so the pipeline can load the selected value straight into X and Y. Bypassing happens only between ALU-class instructions, and each stage has a valid flag so that bubbles never supply data. Load results, stall insertion and the register file are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: If no bypass condition holds, both select codes are 00 (register-file path), `x_val_o` equals `opnd_b_i` and `y_val_o` equals `opnd_c_i`.
- R2: If stage 5 holds a valid ALU instruction whose destination equals the stage-3 `rb`, stage 4 does not match `rb`, and stage 3 holds a valid ALU instruction, then `x_sel_o` is 10 and `x_val_o` equals `z5_i`.
- R3: If stage 5 holds a valid ALU instruction whose destination equals the stage-3 `rc`, stage 4 does not match `rc`, and stage 3 holds a valid non-immediate ALU instruction, then `y_sel_o` is 10 and `y_val_o` equals `z5_i`.
- R4: A stage-4 valid ALU instruction whose destination matches `rb` (or `rc` on a non-immediate instruction) gives select 01 on that operand, and the operand value equals `z4_i`.
- R5: When stage 4 and stage 5 both match the same operand, stage 4 wins: select 01 and value `z4_i`.
- R6: When `s3_imm_i` is 1, `y_sel_o` is 00 and `y_val_o` equals `opnd_c_i`, whatever `rc` matches. The X path is unaffected.
- R7: A producer stage with its ALU flag at 0, or a stage-3 instruction with its ALU flag at 0, never causes a bypass.
- R8: A producer stage with its valid flag at 0 never causes a bypass, and a stage-3 instruction with its valid flag at 0 receives no bypass.
- R9: With `ZERO_HARDWIRED` = 1 (default), a producer destination of register 0 never causes a bypass.
- R10: Select code 11 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s3_valid_i | input | 1 | Stage-3 slot holds a real instruction |
| s3_alu_i | input | 1 | Stage-3 instruction is ALU class |
| s3_imm_i | input | 1 | Stage-3 instruction uses an immediate for its second operand |
| s3_rb_i | input | REG_W | Stage-3 first source register |
| s3_rc_i | input | REG_W | Stage-3 second source register |
| s4_valid_i | input | 1 | Stage-4 slot holds a real instruction |
| s4_alu_i | input | 1 | Stage-4 instruction is ALU class |
| s4_ra_i | input | REG_W | Stage-4 destination register |
| s5_valid_i | input | 1 | Stage-5 slot holds a real instruction |
| s5_alu_i | input | 1 | Stage-5 instruction is ALU class |
| s5_ra_i | input | REG_W | Stage-5 destination register |
| opnd_b_i | input | DATA_W | Register-file value for the first operand |
| opnd_c_i | input | DATA_W | Register-file or immediate value for the second operand |
| z4_i | input | DATA_W | Stage-4 result bus |
| z5_i | input | DATA_W | Stage-5 result bus |
| x_sel_o | output | 2 | X source: 00 file, 01 Z4, 10 Z5 |
| y_sel_o | output | 2 | Y source: 00 file/immediate, 01 Z4, 10 Z5 |
| x_val_o | output | DATA_W | Selected X operand |
| y_val_o | output | DATA_W | Selected Y operand |

## Verification
The block holds no state, so any fault in its comparison or priority logic shows at the ports in the same evaluation as the input pattern that triggers it. A wrong select code and a wrong operand word appear together. A broken priority shows only when both producers name the same register, and a lost immediate guard shows only when `rc` happens to match a producer. The stimulus therefore draws register numbers from a small range so that such collisions, and destination register 0, are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      FWD_RF = 2'b00,
      FWD_Z4 = 2'b01,
      FWD_Z5 = 2'b10
   } fwd_sel_e;

   localparam int unsigned N_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             prod_ok_i,
   input  logic [REG_W-1:0] prod_dst_i,
   input  logic             src_used_i,
   input  logic [REG_W-1:0] src_reg_i,
   output logic             hit_o
);
   logic same_reg;
   logic dst_real;

   assign same_reg = (prod_dst_i == src_reg_i);

   generate
      if (ZERO_HARDWIRED) begin : g_zero_fixed
         assign dst_real = |prod_dst_i;
      end else begin : g_zero_normal
         assign dst_real = 1'b1;
      end
   endgenerate

   assign hit_o = prod_ok_i & src_used_i & dst_real & same_reg;
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     hit_near_i,
   input  logic     hit_far_i,
   output fwd_sel_e sel_o
);
   always_comb begin
      if (hit_near_i)      sel_o = FWD_Z4;
      else if (hit_far_i)  sel_o = FWD_Z5;
      else                 sel_o = FWD_RF;
   end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e          sel_i,
   input  logic [DATA_W-1:0] file_i,
   input  logic [DATA_W-1:0] near_i,
   input  logic [DATA_W-1:0] far_i,
   output logic [DATA_W-1:0] val_o
);
   always_comb begin
      unique case (sel_i)
         FWD_Z4:  val_o = near_i;
         FWD_Z5:  val_o = far_i;
         default: val_o = file_i;
      endcase
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W          = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic              s3_valid_i,
   input  logic              s3_alu_i,
   input  logic              s3_imm_i,
   input  logic [REG_W-1:0]  s3_rb_i,
   input  logic [REG_W-1:0]  s3_rc_i,
   input  logic              s4_valid_i,
   input  logic              s4_alu_i,
   input  logic [REG_W-1:0]  s4_ra_i,
   input  logic              s5_valid_i,
   input  logic              s5_alu_i,
   input  logic [REG_W-1:0]  s5_ra_i,
   input  logic [DATA_W-1:0] opnd_b_i,
   input  logic [DATA_W-1:0] opnd_c_i,
   input  logic [DATA_W-1:0] z4_i,
   input  logic [DATA_W-1:0] z5_i,
   output logic [1:0]        x_sel_o,
   output logic [1:0]        y_sel_o,
   output logic [DATA_W-1:0] x_val_o,
   output logic [DATA_W-1:0] y_val_o
);
   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("fwd_unit: REG_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("fwd_unit: DATA_W must be positive");
      end
   endgenerate

   logic              consumer_ok;
   logic              near_ok;
   logic              far_ok;
   logic [REG_W-1:0]  src_reg  [N_OPND];
   logic              src_used [N_OPND];
   logic [DATA_W-1:0] file_val [N_OPND];
   logic [DATA_W-1:0] out_val  [N_OPND];
   fwd_sel_e          sel      [N_OPND];

   assign consumer_ok = s3_valid_i & s3_alu_i;
   assign near_ok     = s4_valid_i & s4_alu_i;
   assign far_ok      = s5_valid_i & s5_alu_i;

   assign src_reg[0]  = s3_rb_i;
   assign src_reg[1]  = s3_rc_i;
   assign src_used[0] = consumer_ok;
   assign src_used[1] = consumer_ok & ~s3_imm_i;
   assign file_val[0] = opnd_b_i;
   assign file_val[1] = opnd_c_i;

   for (genvar g = 0; g < N_OPND; g++) begin : g_lane
      logic hit_near;
      logic hit_far;

      fwd_match #(.REG_W(REG_W), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_near (
         .prod_ok_i  (near_ok),
         .prod_dst_i (s4_ra_i),
         .src_used_i (src_used[g]),
         .src_reg_i  (src_reg[g]),
         .hit_o      (hit_near)
      );

      fwd_match #(.REG_W(REG_W), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_far (
         .prod_ok_i  (far_ok),
         .prod_dst_i (s5_ra_i),
         .src_used_i (src_used[g]),
         .src_reg_i  (src_reg[g]),
         .hit_o      (hit_far)
      );

      fwd_pick u_pick (
         .hit_near_i (hit_near),
         .hit_far_i  (hit_far),
         .sel_o      (sel[g])
      );

      fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
         .sel_i  (sel[g]),
         .file_i (file_val[g]),
         .near_i (z4_i),
         .far_i  (z5_i),
         .val_o  (out_val[g])
      );
   end

   assign x_sel_o = sel[0];
   assign y_sel_o = sel[1];
   assign x_val_o = out_val[0];
   assign y_val_o = out_val[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned REG_W          = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input logic              s3_valid_i,
   input logic              s3_alu_i,
   input logic              s3_imm_i,
   input logic              s4_valid_i,
   input logic              s4_alu_i,
   input logic [REG_W-1:0]  s4_ra_i,
   input logic              s5_valid_i,
   input logic              s5_alu_i,
   input logic [REG_W-1:0]  s5_ra_i,
   input logic [DATA_W-1:0] opnd_c_i,
   input logic [DATA_W-1:0] z4_i,
   input logic [DATA_W-1:0] z5_i,
   input logic [1:0]        x_sel_o,
   input logic [1:0]        y_sel_o,
   input logic [DATA_W-1:0] x_val_o,
   input logic [DATA_W-1:0] y_val_o
);
   always_comb begin
      a_r10_sel_legal: assert (x_sel_o != 2'b11 && y_sel_o != 2'b11);
      if (s3_imm_i)
         a_r6_imm_keeps_y: assert (y_sel_o == 2'b00 && y_val_o == opnd_c_i);
      if (!(s3_valid_i && s3_alu_i))
         a_r7_r8_no_consumer: assert (x_sel_o == 2'b00 && y_sel_o == 2'b00);
      if (x_sel_o == 2'b01 || y_sel_o == 2'b01)
         a_r8_near_producer_live: assert (s4_valid_i && s4_alu_i);
      if (x_sel_o == 2'b10 || y_sel_o == 2'b10)
         a_r8_far_producer_live: assert (s5_valid_i && s5_alu_i);
      if (x_sel_o == 2'b01)
         a_r4_x_near_data: assert (x_val_o == z4_i);
      if (x_sel_o == 2'b10)
         a_r2_x_far_data: assert (x_val_o == z5_i);
      if (y_sel_o == 2'b10)
         a_r3_y_far_data: assert (y_val_o == z5_i);
      if (ZERO_HARDWIRED && (x_sel_o == 2'b01 || y_sel_o == 2'b01))
         a_r9_near_not_zero: assert (s4_ra_i != '0);
      if (ZERO_HARDWIRED && (x_sel_o == 2'b10 || y_sel_o == 2'b10))
         a_r9_far_not_zero: assert (s5_ra_i != '0);
   end
endmodule

bind fwd_unit fwd_unit_chk #(
   .REG_W(REG_W), .DATA_W(DATA_W), .ZERO_HARDWIRED(ZERO_HARDWIRED)
) u_chk (
   .s3_valid_i (s3_valid_i),
   .s3_alu_i   (s3_alu_i),
   .s3_imm_i   (s3_imm_i),
   .s4_valid_i (s4_valid_i),
   .s4_alu_i   (s4_alu_i),
   .s4_ra_i    (s4_ra_i),
   .s5_valid_i (s5_valid_i),
   .s5_alu_i   (s5_alu_i),
   .s5_ra_i    (s5_ra_i),
   .opnd_c_i   (opnd_c_i),
   .z4_i       (z4_i),
   .z5_i       (z5_i),
   .x_sel_o    (x_sel_o),
   .y_sel_o    (y_sel_o),
   .x_val_o    (x_val_o),
   .y_val_o    (y_val_o)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
   localparam int RW = 5;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic          s3_valid, s3_alu, s3_imm, s4_valid, s4_alu, s5_valid, s5_alu;
   logic [RW-1:0] s3_rb, s3_rc, s4_ra, s5_ra;
   logic [DW-1:0] opnd_b, opnd_c, z4, z5;
   logic [1:0]    x_sel, y_sel;
   logic [DW-1:0] x_val, y_val;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   fwd_unit #(.REG_W(RW), .DATA_W(DW), .ZERO_HARDWIRED(1'b1)) uut (
      .s3_valid_i(s3_valid), .s3_alu_i(s3_alu), .s3_imm_i(s3_imm),
      .s3_rb_i(s3_rb), .s3_rc_i(s3_rc),
      .s4_valid_i(s4_valid), .s4_alu_i(s4_alu), .s4_ra_i(s4_ra),
      .s5_valid_i(s5_valid), .s5_alu_i(s5_alu), .s5_ra_i(s5_ra),
      .opnd_b_i(opnd_b), .opnd_c_i(opnd_c), .z4_i(z4), .z5_i(z5),
      .x_sel_o(x_sel), .y_sel_o(y_sel), .x_val_o(x_val), .y_val_o(y_val)
   );

   // Behavioural model of one operand's source choice.
   function automatic int pick_src(input bit used, input logic [RW-1:0] src);
      bit near, far;
      if (!used || !(s3_valid && s3_alu)) return 0;
      near = s4_valid && s4_alu && s4_ra != 0 && s4_ra == src;
      far  = s5_valid && s5_alu && s5_ra != 0 && s5_ra == src;
      if (near) return 1;
      if (far)  return 2;
      return 0;
   endfunction

   function automatic logic [DW-1:0] src_data(input int code, input logic [DW-1:0] f);
      case (code)
         1: return z4;
         2: return z5;
         default: return f;
      endcase
   endfunction

   task automatic cmp(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      int xe, ye;
      xe = pick_src(1'b1, s3_rb);
      ye = pick_src(!s3_imm, s3_rc);
      cmp(tag, "x_sel", {30'd0, x_sel}, xe);
      cmp(tag, "y_sel", {30'd0, y_sel}, ye);
      cmp(tag, "x_val", x_val, src_data(xe, opnd_b));
      cmp(tag, "y_val", y_val, src_data(ye, opnd_c));
   endtask

   task automatic drive(input bit v3, a3, im, input int rb, rc,
                        input bit v4, a4, input int ra4,
                        input bit v5, a5, input int ra5);
      s3_valid = v3; s3_alu = a3; s3_imm = im;
      s3_rb = RW'(rb); s3_rc = RW'(rc);
      s4_valid = v4; s4_alu = a4; s4_ra = RW'(ra4);
      s5_valid = v5; s5_alu = a5; s5_ra = RW'(ra5);
   endtask

   // Drive after a rising edge, sample at the following falling edge.
   task automatic step(input string tag);
      @(posedge clk); #1;
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      drive(0,0,0,0,0, 0,0,0, 0,0,0);
      opnd_b = 32'hB0B0_0001; opnd_c = 32'hC0C0_0002;
      z4 = 32'h4444_0004;     z5 = 32'h5555_0005;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_all("R1 reset");

      @(posedge clk); #1; drive(1,1,0,3,7, 1,1,9, 1,1,10);
      step("R1");
      @(posedge clk); #1; drive(1,1,0,3,7, 0,0,0, 1,1,3);
      step("R2");
      @(posedge clk); #1; drive(1,1,0,3,7, 1,1,12, 1,1,7);
      step("R3");
      @(posedge clk); #1; drive(1,1,0,6,6, 1,1,6, 1,1,2);
      step("R4");
      @(posedge clk); #1; drive(1,1,0,5,5, 1,1,5, 1,1,5);
      step("R5");
      @(posedge clk); #1; drive(1,1,1,4,8, 1,1,8, 1,1,8);
      step("R6");
      @(posedge clk); #1; drive(1,1,1,8,8, 1,1,20, 1,1,8);
      step("R6 x_only");
      @(posedge clk); #1; drive(1,1,0,2,3, 1,0,2, 1,0,3);
      step("R7 producer");
      @(posedge clk); #1; drive(1,0,0,2,3, 1,1,2, 1,1,3);
      step("R7 consumer");
      @(posedge clk); #1; drive(1,1,0,2,3, 0,1,2, 0,1,3);
      step("R8 bubble");
      @(posedge clk); #1; drive(0,1,0,2,3, 1,1,2, 1,1,3);
      step("R8 s3_bubble");
      @(posedge clk); #1; drive(1,1,0,0,0, 1,1,0, 1,1,0);
      step("R9");

      for (int i = 0; i < 400; i++) begin
         @(posedge clk); #1;
         drive($urandom_range(0,7) != 0, $urandom_range(0,5) != 0, $urandom_range(0,3) == 0,
               $urandom_range(0,3), $urandom_range(0,3),
               $urandom_range(0,5) != 0, $urandom_range(0,4) != 0, $urandom_range(0,3),
               $urandom_range(0,5) != 0, $urandom_range(0,4) != 0, $urandom_range(0,3));
         opnd_b = $urandom; opnd_c = $urandom; z4 = $urandom; z5 = $urandom;
         @(negedge clk);
         check_all("R10 random");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule